// File: doc/BRIEF.md
# Scanline Sprite Evaluator and Pixel Shifter

This block chooses the sprites that appear on one raster line and produces their pixels as the line is drawn. A scan is started with a pulse and a line number. The block then reads the object table one entry per cycle through a combinational read port. Each entry is a 32-bit word holding the top row Y, the tile number, the attribute byte and the left column X. Up to eight entries whose vertical band covers the requested line are copied, in table order, into eight slots. A ninth entry in range sets a sticky overflow flag.

Pattern bytes come from outside the block. After a scan, the fetch unit selects a slot and reads its tile number and pattern row, with vertical flip already applied. It then writes the two pattern bit-planes back into that slot. During the visible line, each `pix_en` strobe advances one column. Every slot counts its X value down to zero and then shifts out its eight 2-bit pixels. The block presents the winning sprite pixel with its palette and behind-background bit. It also keeps a sprite-zero collision flag, computed against the background pixel supplied for the same column. The two flags are cleared by a frame-start pulse.

The expected sequence for each line is: scan, load the patterns, then strobe 256 columns. Scan, load and draw do not overlap.

Top module: `spr_line_unit`

## Requirements
- R1: A scan starts only when `eval_start` is high while `eval_busy` is low. It keeps `eval_busy` high for exactly 64 cycles and visits `oam_addr` 0 to 63 in order. A start request during a scan is ignored.
- R2: An entry is in range when `next_line - Y` is between 0 and H-1, where H is 8 when `tall_mode` is 0 and 16 when it is 1. An entry whose Y is above the line does not match through wraparound. `fetch_row` reports `next_line - Y`.
- R3: In-range entries fill slots 0 to 7 in ascending table order. `fetch_tile` returns the tile byte of the slot's entry. Exactly eight in-range entries leave `overflow` low, and a ninth sets it.
- R4: With `pix_en` strobes counting columns from 0 after a scan, a slot with X = x is transparent for columns below x. It emits pattern bits 7 down to 0 on columns x to x+7 as pixel {hi bit, lo bit}, and is transparent afterwards.
- R5: Pixel value 0 is transparent. When several slots are opaque in a column, the slot from the lowest table index wins, and a transparent pixel of a lower-indexed sprite lets a higher one show.
- R6: Attribute bit 6 reverses the pattern horizontally, so pattern bit 0 appears at column x. Attribute bit 7 reports `fetch_row` as H-1 minus the row offset.
- R7: `spr_pal` carries attribute bits 1:0 of the winning sprite and `spr_behind` carries its attribute bit 5. Both are 0 when no sprite is opaque.
- R8: `zero_hit` sets after a strobed column in which table entry 0 gives an opaque pixel and `bg_pix` is nonzero. No other entry can set it, and a zero background never sets it.
- R9: After reset both flags are low. Once set, `overflow` and `zero_hit` stay set until a `frame_start` pulse clears them on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Clears the overflow and collision flags |
| eval_start | input | 1 | Starts a 64-entry scan |
| next_line | input | 8 | Line to be drawn next |
| tall_mode | input | 1 | 0: 8-row sprites, 1: 16-row sprites |
| oam_addr | output | 6 | Object table entry being read |
| oam_entry | input | 32 | Entry data {Y, tile, attr, X}, Y in bits 31:24 |
| eval_busy | output | 1 | Scan in progress |
| load_en | input | 1 | Write pattern planes into the selected slot |
| load_slot | input | 3 | Slot selected for fetch and load |
| pat_lo | input | 8 | Low bit-plane of the pattern row |
| pat_hi | input | 8 | High bit-plane of the pattern row |
| fetch_used | output | 1 | Selected slot holds a sprite |
| fetch_tile | output | 8 | Tile number of the selected slot |
| fetch_row | output | 4 | Pattern row of the selected slot, flip applied |
| pix_en | input | 1 | Advance one column |
| bg_pix | input | 2 | Background pixel of the current column |
| spr_pix | output | 2 | Winning sprite pixel, 0 if none |
| spr_pal | output | 2 | Palette of the winning sprite |
| spr_behind | output | 1 | Behind-background bit of the winning sprite |
| overflow | output | 1 | More than eight sprites in range since frame start |
| zero_hit | output | 1 | Sprite-zero collision since frame start |

## Verification
The hardest case to create is the collision flag's dependence on a single column in which entry 0 is opaque and the background is nonzero at the same time. A background pixel one column too early must not set it, and other sprites over an opaque background must not set it either. The bench places entry 0 at a known column with a solid pattern. It draws one line with a lone opaque background column just before the sprite, which must not set the flag. It then draws a fresh line with the background column inside the sprite, which must set it. Overflow is reached by filling exactly eight, and then ten, in-range entries.

// File: rtl/spr_pkg.sv
package spr_pkg;

    localparam int ATTR_PAL_LO = 0;
    localparam int ATTR_BEHIND = 5;
    localparam int ATTR_HFLIP  = 6;
    localparam int ATTR_VFLIP  = 7;

    typedef struct packed {
        logic [7:0] ypos;
        logic [7:0] tile;
        logic [7:0] attr;
        logic [7:0] xpos;
    } oam_ent_t;

    typedef struct packed {
        logic [7:0] tile;
        logic [7:0] attr;
        logic [7:0] xpos;
        logic [3:0] row;
        logic       zero;
    } slot_rec_t;

    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    // returns {in_range, row}
    function automatic logic [4:0] row_probe(input logic [7:0] line, input logic [7:0] y,
                                             input logic tall, input logic vflip);
        logic [8:0] d;
        logic [4:0] h;
        logic [3:0] r;
        d = {1'b0, line} - {1'b0, y};
        h = tall ? 5'd16 : 5'd8;
        r = d[3:0];
        if (vflip) r = (tall ? 4'd15 : 4'd7) - d[3:0];
        return {(!d[8] && (d[7:0] < {3'b000, h})), r};
    endfunction

endpackage

// File: rtl/spr_eval.sv
module spr_eval
    import spr_pkg::*;
#(
    parameter int NUM_SPR  = 64,
    parameter int NUM_SLOT = 8,
    localparam int AW = $clog2(NUM_SPR),
    localparam int CW = $clog2(NUM_SLOT + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_start,
    input  logic                start,
    input  logic [7:0]          line,
    input  logic                tall,
    input  oam_ent_t            entry,
    output logic [AW-1:0]       addr,
    output logic                busy,
    output logic                clr,
    output logic [NUM_SLOT-1:0] wr,
    output slot_rec_t           wdata,
    output logic                overflow
);
    logic [AW-1:0] idx_q;
    logic [CW-1:0] cnt_q;
    logic [7:0]    line_q;
    logic          tall_q, busy_q, ovf_q;
    logic [4:0]    probe;
    logic          hit, room;

    assign probe = row_probe(line_q, entry.ypos, tall_q, entry.attr[ATTR_VFLIP]);
    assign hit   = busy_q && probe[4];
    assign room  = cnt_q < CW'(NUM_SLOT);
    assign clr   = start && !busy_q;

    assign wdata.tile = entry.tile;
    assign wdata.attr = entry.attr;
    assign wdata.xpos = entry.xpos;
    assign wdata.row  = probe[3:0];
    assign wdata.zero = (idx_q == '0);

    for (genvar s = 0; s < NUM_SLOT; s++) begin : g_wr
        assign wr[s] = hit && room && (cnt_q == CW'(s));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            cnt_q  <= '0;
            line_q <= '0;
            tall_q <= 1'b0;
        end else if (clr) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            cnt_q  <= '0;
            line_q <= line;
            tall_q <= tall;
        end else if (busy_q) begin
            if (hit && room) cnt_q <= cnt_q + 1'b1;
            idx_q <= idx_q + 1'b1;
            if (idx_q == AW'(NUM_SPR - 1)) busy_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || frame_start) ovf_q <= 1'b0;
        else if (hit && !room)  ovf_q <= 1'b1;
    end

    assign addr     = idx_q;
    assign busy     = busy_q;
    assign overflow = ovf_q;
endmodule

// File: rtl/spr_slot.sv
module spr_slot
    import spr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       wr,
    input  slot_rec_t  wdata,
    input  logic       load,
    input  logic [7:0] pat_lo,
    input  logic [7:0] pat_hi,
    input  logic       pix_en,
    output logic       used,
    output logic [7:0] tile,
    output logic [3:0] row,
    output logic [1:0] pal,
    output logic       behind,
    output logic       zero,
    output logic [1:0] pix
);
    logic       used_q, zero_q;
    logic [7:0] attr_q, tile_q, xcnt_q, lo_q, hi_q;
    logic [3:0] row_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            used_q <= 1'b0;
            zero_q <= 1'b0;
            attr_q <= '0;
            tile_q <= '0;
            row_q  <= '0;
            xcnt_q <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
        end else begin
            if (wr) begin
                used_q <= 1'b1;
                zero_q <= wdata.zero;
                attr_q <= wdata.attr;
                tile_q <= wdata.tile;
                row_q  <= wdata.row;
                xcnt_q <= wdata.xpos;
            end
            if (load) begin
                lo_q <= attr_q[ATTR_HFLIP] ? rev8(pat_lo) : pat_lo;
                hi_q <= attr_q[ATTR_HFLIP] ? rev8(pat_hi) : pat_hi;
            end else if (pix_en && used_q) begin
                if (xcnt_q != 8'd0) begin
                    xcnt_q <= xcnt_q - 8'd1;
                end else begin
                    lo_q <= {lo_q[6:0], 1'b0};
                    hi_q <= {hi_q[6:0], 1'b0};
                end
            end
        end
    end

    assign used   = used_q;
    assign tile   = tile_q;
    assign row    = row_q;
    assign pal    = attr_q[ATTR_PAL_LO+1:ATTR_PAL_LO];
    assign behind = attr_q[ATTR_BEHIND];
    assign zero   = zero_q;
    assign pix    = (used_q && xcnt_q == 8'd0) ? {hi_q[7], lo_q[7]} : 2'b00;
endmodule

// File: rtl/spr_pick.sv
module spr_pick #(
    parameter int NUM_SLOT = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      frame_start,
    input  logic                      pix_en,
    input  logic [1:0]                bg_pix,
    input  logic [NUM_SLOT-1:0][1:0]  pix,
    input  logic [NUM_SLOT-1:0][1:0]  pal,
    input  logic [NUM_SLOT-1:0]       behind,
    input  logic [NUM_SLOT-1:0]       zero,
    output logic [1:0]                win_pix,
    output logic [1:0]                win_pal,
    output logic                      win_behind,
    output logic                      zero_hit
);
    logic zero_opaque, hit_q;

    always_comb begin
        win_pix     = 2'b00;
        win_pal     = 2'b00;
        win_behind  = 1'b0;
        zero_opaque = 1'b0;
        for (int s = NUM_SLOT - 1; s >= 0; s--) begin
            if (pix[s] != 2'b00) begin
                win_pix    = pix[s];
                win_pal    = pal[s];
                win_behind = behind[s];
                if (zero[s]) zero_opaque = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || frame_start) hit_q <= 1'b0;
        else if (pix_en && zero_opaque && bg_pix != 2'b00) hit_q <= 1'b1;
    end

    assign zero_hit = hit_q;
endmodule

// File: rtl/spr_line_unit.sv
module spr_line_unit
    import spr_pkg::*;
#(
    parameter int NUM_SPR  = 64,
    parameter int NUM_SLOT = 8,
    localparam int OAM_AW  = $clog2(NUM_SPR),
    localparam int SLOT_AW = $clog2(NUM_SLOT)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_start,
    input  logic               eval_start,
    input  logic [7:0]         next_line,
    input  logic               tall_mode,
    output logic [OAM_AW-1:0]  oam_addr,
    input  logic [31:0]        oam_entry,
    output logic               eval_busy,
    input  logic               load_en,
    input  logic [SLOT_AW-1:0] load_slot,
    input  logic [7:0]         pat_lo,
    input  logic [7:0]         pat_hi,
    output logic               fetch_used,
    output logic [7:0]         fetch_tile,
    output logic [3:0]         fetch_row,
    input  logic               pix_en,
    input  logic [1:0]         bg_pix,
    output logic [1:0]         spr_pix,
    output logic [1:0]         spr_pal,
    output logic               spr_behind,
    output logic               overflow,
    output logic               zero_hit
);
    logic                     clr;
    logic [NUM_SLOT-1:0]      wr, used, behind, zero;
    slot_rec_t                wdata;
    logic [NUM_SLOT-1:0][7:0] tile;
    logic [NUM_SLOT-1:0][3:0] row;
    logic [NUM_SLOT-1:0][1:0] pal, pix;

    spr_eval #(.NUM_SPR(NUM_SPR), .NUM_SLOT(NUM_SLOT)) u_eval (
        .clk(clk), .rst(rst), .frame_start(frame_start), .start(eval_start),
        .line(next_line), .tall(tall_mode), .entry(oam_ent_t'(oam_entry)),
        .addr(oam_addr), .busy(eval_busy), .clr(clr), .wr(wr), .wdata(wdata),
        .overflow(overflow)
    );

    for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
        spr_slot u_slot (
            .clk(clk), .rst(rst), .clr(clr), .wr(wr[s]), .wdata(wdata),
            .load(load_en && load_slot == SLOT_AW'(s)),
            .pat_lo(pat_lo), .pat_hi(pat_hi), .pix_en(pix_en),
            .used(used[s]), .tile(tile[s]), .row(row[s]), .pal(pal[s]),
            .behind(behind[s]), .zero(zero[s]), .pix(pix[s])
        );
    end

    assign fetch_used = used[load_slot];
    assign fetch_tile = tile[load_slot];
    assign fetch_row  = row[load_slot];

    spr_pick #(.NUM_SLOT(NUM_SLOT)) u_pick (
        .clk(clk), .rst(rst), .frame_start(frame_start), .pix_en(pix_en),
        .bg_pix(bg_pix), .pix(pix), .pal(pal), .behind(behind), .zero(zero),
        .win_pix(spr_pix), .win_pal(spr_pal), .win_behind(spr_behind),
        .zero_hit(zero_hit)
    );
endmodule

// File: rtl/spr_line_unit_chk.sv
module spr_line_unit_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_start,
    input logic              eval_start,
    input logic              eval_busy,
    input logic [ADDR_W-1:0] oam_addr,
    input logic              pix_en,
    input logic [1:0]        bg_pix,
    input logic [1:0]        spr_pix,
    input logic              overflow,
    input logic              zero_hit
);
    localparam logic [ADDR_W-1:0] LAST = '1;

    a_r1_start_busy: assert property (@(posedge clk) disable iff (rst)
        (eval_start && !eval_busy) |=> (eval_busy && oam_addr == '0));

    a_r1_addr_step: assert property (@(posedge clk) disable iff (rst)
        (eval_busy && oam_addr != LAST) |=> (eval_busy && oam_addr == $past(oam_addr) + 1'b1));

    a_r1_scan_end: assert property (@(posedge clk) disable iff (rst)
        (eval_busy && oam_addr == LAST) |=> !eval_busy);

    a_r3_ovf_during_scan: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow) |-> $past(eval_busy));

    a_r8_hit_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(zero_hit) |-> ($past(pix_en) && $past(bg_pix) != 2'b00 && $past(spr_pix) != 2'b00));

    a_r9_ovf_hold: assert property (@(posedge clk) disable iff (rst)
        (overflow && !frame_start) |=> overflow);

    a_r9_hit_hold: assert property (@(posedge clk) disable iff (rst)
        (zero_hit && !frame_start) |=> zero_hit);

    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (!overflow && !zero_hit));
endmodule

bind spr_line_unit spr_line_unit_chk #(.ADDR_W(OAM_AW)) u_chk (.*);

// File: tb/spr_line_unit_tb_top.sv
`timescale 1ns/1ps
module spr_line_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_start = 1'b0, eval_start = 1'b0, tall_mode = 1'b0;
    logic [7:0] next_line = '0;
    logic [5:0] oam_addr;
    logic [31:0] oam_entry;
    logic       eval_busy;
    logic       load_en = 1'b0;
    logic [2:0] load_slot = '0;
    logic [7:0] pat_lo = '0, pat_hi = '0;
    logic       fetch_used;
    logic [7:0] fetch_tile;
    logic [3:0] fetch_row;
    logic       pix_en = 1'b0;
    logic [1:0] bg_pix = '0;
    logic [1:0] spr_pix, spr_pal;
    logic       spr_behind, overflow, zero_hit;

    logic [31:0] oam [64];
    logic [1:0]  got_pix [256];
    logic [1:0]  got_pal [256];
    logic        got_beh [256];
    int n_chk = 0, n_err = 0;

    always #2.5 clk = ~clk;
    assign oam_entry = oam[oam_addr];

    spr_line_unit dut_i (.*);

    // {y, attr, line, tall, exp_used, exp_row}
    localparam logic [29:0] VEC [10] = '{
        {8'd40,  8'h00, 8'd40, 1'b0, 1'b1, 4'd0},
        {8'd40,  8'h00, 8'd47, 1'b0, 1'b1, 4'd7},
        {8'd40,  8'h00, 8'd48, 1'b0, 1'b0, 4'd0},
        {8'd40,  8'h00, 8'd39, 1'b0, 1'b0, 4'd0},
        {8'd40,  8'h00, 8'd48, 1'b1, 1'b1, 4'd8},
        {8'd40,  8'h00, 8'd55, 1'b1, 1'b1, 4'd15},
        {8'd40,  8'h00, 8'd56, 1'b1, 1'b0, 4'd0},
        {8'd40,  8'h80, 8'd42, 1'b0, 1'b1, 4'd5},
        {8'd40,  8'h80, 8'd42, 1'b1, 1'b1, 4'd13},
        {8'd250, 8'h00, 8'd4,  1'b1, 1'b0, 4'd0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_oam();
        for (int i = 0; i < 64; i++) oam[i] = {8'd240, 8'h00, 8'h00, 8'h00};
    endtask

    task automatic set_spr(input int i, input logic [7:0] y, input logic [7:0] t,
                           input logic [7:0] a, input logic [7:0] x);
        oam[i] = {y, t, a, x};
    endtask

    task automatic pulse_frame();
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
    endtask

    task automatic run_eval(input logic [7:0] line, input logic tall, output int cycles);
        @(negedge clk);
        eval_start = 1'b1; next_line = line; tall_mode = tall;
        @(negedge clk);
        eval_start = 1'b0;
        cycles = 0;
        while (eval_busy) begin
            cycles++;
            @(negedge clk);
        end
    endtask

    task automatic load(input int s, input logic [7:0] lo, input logic [7:0] hi);
        @(negedge clk);
        load_en = 1'b1; load_slot = 3'(s); pat_lo = lo; pat_hi = hi;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic draw(input logic [1:0] bg_all, input int bg_col, input logic [1:0] bg_at);
        for (int c = 0; c < 256; c++) begin
            @(negedge clk);
            pix_en = 1'b1;
            bg_pix = (c == bg_col) ? bg_at : bg_all;
            #1;
            got_pix[c] = spr_pix;
            got_pal[c] = spr_pal;
            got_beh[c] = spr_behind;
        end
        @(negedge clk);
        pix_en = 1'b0; bg_pix = 2'b00;
    endtask

    initial begin
        #(5.0 * 150000);
        n_err++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int cyc;
        clear_oam();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        // R9 reset state
        chk("R9 reset overflow", int'(overflow), 0);
        chk("R9 reset zero_hit", int'(zero_hit), 0);
        chk("R5 reset spr_pix", int'(spr_pix), 0);
        chk("R1 reset busy", int'(eval_busy), 0);

        // R1 scan length, start ignored during scan
        @(negedge clk);
        eval_start = 1'b1; next_line = 8'd10; tall_mode = 1'b0;
        @(negedge clk);
        cyc = 0;
        repeat (5) begin
            if (eval_busy) cyc++;
            @(negedge clk);
        end
        eval_start = 1'b0;
        while (eval_busy) begin
            cyc++;
            @(negedge clk);
        end
        chk("R1 scan cycles with held start", cyc, 64);

        // R2 vector table
        for (int v = 0; v < 10; v++) begin
            logic [29:0] e;
            e = VEC[v];
            clear_oam();
            set_spr(5, e[29:22], 8'h5A, e[21:14], 8'd20);
            run_eval(e[13:6], e[5], cyc);
            load_slot = 3'd0;
            #1;
            chk($sformatf("R2 vec%0d used", v), int'(fetch_used), int'(e[4]));
            if (e[4]) begin
                chk($sformatf("R2 R6 vec%0d row", v), int'(fetch_row), int'(e[3:0]));
                chk($sformatf("R3 vec%0d tile", v), int'(fetch_tile), 8'h5A);
            end
        end

        // R3 exactly eight in range: no overflow, ordered fill
        clear_oam();
        for (int i = 0; i < 8; i++) set_spr(i * 3, 8'd20, 8'(8'h10 + i), 8'h00, 8'd0);
        run_eval(8'd22, 1'b0, cyc);
        chk("R3 eight no overflow", int'(overflow), 0);
        for (int s = 0; s < 8; s++) begin
            load_slot = 3'(s);
            #1;
            chk("R3 slot used", int'(fetch_used), 1);
            chk("R3 slot order tile", int'(fetch_tile), 8'h10 + s);
        end
        // ten in range
        clear_oam();
        for (int i = 0; i < 10; i++) set_spr(i, 8'd20, 8'(8'h30 + i), 8'h00, 8'd0);
        run_eval(8'd22, 1'b0, cyc);
        chk("R3 ninth sets overflow", int'(overflow), 1);
        load_slot = 3'd7;
        #1;
        chk("R3 slot7 tile", int'(fetch_tile), 8'h37);
        clear_oam();
        run_eval(8'd22, 1'b0, cyc);
        chk("R9 overflow sticky", int'(overflow), 1);
        pulse_frame();
        #1;
        chk("R9 frame_start clears overflow", int'(overflow), 0);

        // R4 pixel stream
        clear_oam();
        set_spr(2, 8'd30, 8'h01, 8'h01, 8'd10);
        run_eval(8'd30, 1'b0, cyc);
        load(0, 8'hF0, 8'h0F);
        draw(2'b00, -1, 2'b00);
        chk("R4 col9 transparent", int'(got_pix[9]), 0);
        chk("R4 col10", int'(got_pix[10]), 1);
        chk("R4 col13", int'(got_pix[13]), 1);
        chk("R4 col14", int'(got_pix[14]), 2);
        chk("R4 col17", int'(got_pix[17]), 2);
        chk("R4 col18 done", int'(got_pix[18]), 0);
        chk("R7 palette", int'(got_pal[10]), 1);

        // R6 horizontal flip
        clear_oam();
        set_spr(4, 8'd30, 8'h02, 8'h40, 8'd100);
        run_eval(8'd30, 1'b0, cyc);
        load(0, 8'h80, 8'h00);
        draw(2'b00, -1, 2'b00);
        chk("R6 hflip col100", int'(got_pix[100]), 0);
        chk("R6 hflip col106", int'(got_pix[106]), 0);
        chk("R6 hflip col107", int'(got_pix[107]), 1);

        // R5 R7 priority, non-zero sprites over opaque background
        clear_oam();
        set_spr(1, 8'd30, 8'h03, 8'h21, 8'd0);
        set_spr(3, 8'd30, 8'h04, 8'h02, 8'd0);
        run_eval(8'd30, 1'b0, cyc);
        load(0, 8'hAA, 8'h00);
        load(1, 8'hFF, 8'hFF);
        draw(2'b11, -1, 2'b00);
        chk("R5 col0 lower index wins", int'(got_pix[0]), 1);
        chk("R7 col0 pal", int'(got_pal[0]), 1);
        chk("R7 col0 behind", int'(got_beh[0]), 1);
        chk("R5 col1 through transparent", int'(got_pix[1]), 3);
        chk("R7 col1 pal", int'(got_pal[1]), 2);
        chk("R7 col1 behind", int'(got_beh[1]), 0);
        chk("R5 col8 none", int'(got_pix[8]), 0);
        chk("R7 col8 pal zero", int'(got_pal[8]), 0);
        chk("R8 other sprites no hit", int'(zero_hit), 0);

        // R8 sprite zero collision
        clear_oam();
        set_spr(0, 8'd30, 8'h05, 8'h00, 8'd50);
        run_eval(8'd30, 1'b0, cyc);
        load(0, 8'hFF, 8'h00);
        draw(2'b00, 49, 2'b01);
        chk("R8 bg before sprite no hit", int'(zero_hit), 0);
        run_eval(8'd30, 1'b0, cyc);
        load(0, 8'hFF, 8'h00);
        draw(2'b00, 52, 2'b01);
        chk("R8 overlap sets hit", int'(zero_hit), 1);
        run_eval(8'd30, 1'b0, cyc);
        load(0, 8'hFF, 8'h00);
        draw(2'b00, -1, 2'b00);
        chk("R9 hit sticky", int'(zero_hit), 1);
        pulse_frame();
        #1;
        chk("R9 frame_start clears hit", int'(zero_hit), 0);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule